// File: doc/BRIEF.md
# Dual Capture/Compare/PWM Timer Channel

This block holds two timer channels that watch one shared free-running 16-bit counter. The counter and its overflow pulse come from outside. Each channel owns an 8-bit control/status byte, a 16-bit compare/capture register, one input pin, one output pin with an enable, a flag and an interrupt request.

In capture mode a channel copies the counter into its register on a chosen pin edge. In compare mode it drives its output high, low or toggled whenever the counter equals its register. A channel can also toggle its output on each counter overflow, which gives the period edge of a PWM waveform. A forced-high setting gives full duty.

The even channel can take over both registers for buffered operation. It then alternates between the two compare values on successive overflows, so software can reload the idle one without a glitch. While this runs, the odd channel is idle and its pin is released. A byte-wide port with a write strobe and a combinational read gives access to all six registers.

Top module: `tmr_chan_pair`

## Requirements
- R1: After reset every register reads 0x00, and pin_out, pin_oe and irq are all 0.
- R2: The flag (control bit 7) is set by a capture or compare event. Writing the control byte with bit 7 = 0 clears it, and writing bit 7 = 1 leaves it unchanged. If an event falls in the same cycle as a clearing write, the flag stays 1.
- R3: Register addresses are: channel n control byte at 3n, its register high byte at 3n+1, low byte at 3n+2. Unused addresses read 0. Control bit 6 = interrupt enable, bit 5 = mode B, bit 4 = mode A, bits 3:2 = edge/level select, bit 1 = toggle on overflow, bit 0 = full duty. On channel 1, bit 5 always reads 0.
- R4: irq[n] is 1 exactly when channel n's flag and interrupt enable are both 1.
- R5: With mode bits 5:4 = 00 the channel captures. Edge select 01 means rising, 10 means falling, 11 means either edge, and 00 means no capture. The counter value present at the clock edge where the pin change is first sampled is written to the channel register and sets the flag.
- R6: With mode bits 5:4 other than 00 the channel compares. When the counter equals the register, the flag is set and the output takes the action chosen by edge select (01 toggle, 10 low, 11 high). The action is visible after that clock edge.
- R7: In compare mode with bit 1 set, each overflow pulse toggles the output. If a match falls in the same cycle, the match action is applied and the toggle is skipped.
- R8: In compare mode with bit 0 set, the output is driven 1. Matches still set the flag but do not change the output.
- R9: When channel 0 has bit 5 set, it compares against channel 0's register first and swaps to the other register on each overflow. Channel 1 then sets no flag and has pin_oe[1] = 0.
- R10: pin_oe[n] is 1 only when the channel is in compare mode with edge select other than 00 and is not idled by R9. While pin_oe[n] is 0, pin_out[n] holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Shared free-running counter value |
| cnt_ovf | input | 1 | One-cycle counter overflow pulse |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from bus_addr) |
| pin_in | input | 2 | Channel input pins, synchronous to clk |
| pin_out | output | 2 | Channel output levels |
| pin_oe | output | 2 | Channel output enables |
| irq | output | 2 | Per-channel interrupt requests |

## Verification
The flag can receive a hardware event and a software clearing write in the same cycle. The bench provokes this by writing the control byte with bit 7 low while raising the capture pin, and then expects the flag to read back as 1 along with the new captured value. A compare match can also coincide with an overflow. The bench drives a matching counter value together with the overflow pulse while the output is already high and the action is set-high, so a wrongly applied toggle would show up as a low output.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  typedef struct packed {
    logic flag;
    logic ie;
    logic mode_b;
    logic mode_a;
    logic sel_b;
    logic sel_a;
    logic tog_ovf;
    logic full_duty;
  } ctl_t;

  localparam int REG_STRIDE = 3;
  localparam int REG_CTL    = 0;
  localparam int REG_HI     = 1;
  localparam int REG_LO     = 2;

  localparam logic [1:0] SEL_OFF  = 2'b00;
  localparam logic [1:0] SEL_TOG  = 2'b01;
  localparam logic [1:0] SEL_LOW  = 2'b10;
  localparam logic [1:0] SEL_HIGH = 2'b11;
endpackage

// File: rtl/tcp_regs.sv
module tcp_regs #(
  parameter int CNT_W = 16,
  parameter int AW    = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_we,
  input  logic [AW-1:0]               bus_addr,
  input  logic [7:0]                  bus_wdata,
  output logic [7:0]                  bus_rdata,
  input  logic [CNT_W-1:0]            cnt_val,
  input  logic [1:0]                  evt,
  input  logic [1:0]                  cap_we,
  output tcp_pkg::ctl_t [1:0]         ctl,
  output logic [1:0][CNT_W-1:0]       cmp
);
  import tcp_pkg::*;

  localparam int HI_W = CNT_W - 8;

  ctl_t [1:0]             ctl_n;
  logic [1:0][CNT_W-1:0]  cmp_n;
  logic [1:0]             hit_ctl, hit_hi, hit_lo;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    localparam logic [AW-1:0] A_CTL = AW'(REG_STRIDE * i + REG_CTL);
    localparam logic [AW-1:0] A_HI  = AW'(REG_STRIDE * i + REG_HI);
    localparam logic [AW-1:0] A_LO  = AW'(REG_STRIDE * i + REG_LO);

    always_comb begin
      hit_ctl[i] = bus_we && (bus_addr == A_CTL);
      hit_hi[i]  = bus_we && (bus_addr == A_HI);
      hit_lo[i]  = bus_we && (bus_addr == A_LO);

      ctl_n[i] = ctl[i];
      if (hit_ctl[i]) begin
        ctl_n[i].ie        = bus_wdata[6];
        ctl_n[i].mode_b    = (i == 0) ? bus_wdata[5] : 1'b0;
        ctl_n[i].mode_a    = bus_wdata[4];
        ctl_n[i].sel_b     = bus_wdata[3];
        ctl_n[i].sel_a     = bus_wdata[2];
        ctl_n[i].tog_ovf   = bus_wdata[1];
        ctl_n[i].full_duty = bus_wdata[0];
      end
      ctl_n[i].flag = evt[i] | (ctl[i].flag & ~(hit_ctl[i] & ~bus_wdata[7]));

      cmp_n[i] = cmp[i];
      if (cap_we[i]) begin
        cmp_n[i] = cnt_val;
      end else begin
        if (hit_hi[i]) cmp_n[i][CNT_W-1:8] = bus_wdata[HI_W-1:0];
        if (hit_lo[i]) cmp_n[i][7:0]       = bus_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctl[i] <= '0;
        cmp[i] <= '0;
      end else begin
        ctl[i] <= ctl_n[i];
        cmp[i] <= cmp_n[i];
      end
    end

    p_flag_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl[i].flag) |-> $past(evt[i]));

    p_flag_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ctl[i] && !bus_wdata[7] && !evt[i]) |=> !ctl[i].flag);

    p_flag_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i].flag && !hit_ctl[i]) |=> ctl[i].flag);
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < 2; i++) begin
      if (bus_addr == AW'(REG_STRIDE * i + REG_CTL)) bus_rdata = ctl[i];
      if (bus_addr == AW'(REG_STRIDE * i + REG_HI))  bus_rdata = 8'(cmp[i][CNT_W-1:8]);
      if (bus_addr == AW'(REG_STRIDE * i + REG_LO))  bus_rdata = cmp[i][7:0];
    end
  end
endmodule

// File: rtl/tcp_chan.sv
module tcp_chan #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tcp_pkg::ctl_t      ctl,
  input  logic [CNT_W-1:0]   cmp_val,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               cnt_ovf,
  input  logic               pin_in,
  input  logic               active,
  output logic               evt,
  output logic               cap_we,
  output logic               pin_out,
  output logic               pin_oe
);
  import tcp_pkg::*;

  logic       pin_q;
  logic       out_q, out_n;
  logic [1:0] sel;
  logic       is_cap, is_cmp, rise, fall, edge_hit, match, drive;

  always_comb begin
    sel    = {ctl.sel_b, ctl.sel_a};
    is_cap = !ctl.mode_b && !ctl.mode_a;
    is_cmp = !is_cap;
    rise   = pin_in && !pin_q;
    fall   = !pin_in && pin_q;
    unique case (sel)
      SEL_TOG:  edge_hit = rise;
      SEL_LOW:  edge_hit = fall;
      SEL_HIGH: edge_hit = rise || fall;
      default:  edge_hit = 1'b0;
    endcase
    cap_we = active && is_cap && edge_hit;
    match  = active && is_cmp && (cnt_val == cmp_val);
    evt    = cap_we || match;
    drive  = active && is_cmp && (sel != SEL_OFF);

    out_n = out_q;
    if (drive) begin
      if (ctl.full_duty) begin
        out_n = 1'b1;
      end else if (match) begin
        unique case (sel)
          SEL_TOG:  out_n = !out_q;
          SEL_LOW:  out_n = 1'b0;
          SEL_HIGH: out_n = 1'b1;
          default:  out_n = out_q;
        endcase
      end else if (ctl.tog_ovf && cnt_ovf) begin
        out_n = !out_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      pin_q <= pin_in;
      out_q <= out_n;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = drive;

  p_full_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && ctl.full_duty) |=> pin_out);

  p_match_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && !ctl.full_duty && evt && sel == SEL_HIGH) |=> pin_out);

  p_match_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && !ctl.full_duty && evt && sel == SEL_LOW) |=> !pin_out);

  p_ovf_tog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe && !ctl.full_duty && !evt && ctl.tog_ovf && cnt_ovf)
      |=> pin_out != $past(pin_out));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |=> $stable(pin_out));

  p_cap_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |-> (!pin_oe && pin_in != pin_q));
endmodule

// File: rtl/tcp_buf_sel.sv
module tcp_buf_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic buf_en,
  input  logic cnt_ovf,
  output logic use_odd
);
  logic use_odd_n;

  always_comb begin
    use_odd_n = use_odd;
    if (!buf_en)      use_odd_n = 1'b0;
    else if (cnt_ovf) use_odd_n = !use_odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) use_odd <= 1'b0;
    else        use_odd <= use_odd_n;
  end

  p_sel_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_en |=> !use_odd);

  p_sel_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && cnt_ovf) |=> use_odd != $past(use_odd));

  p_sel_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en && !cnt_ovf) |=> $stable(use_odd));
endmodule

// File: rtl/tmr_chan_pair.sv
module tmr_chan_pair #(
  parameter int CNT_W = 16,
  parameter int AW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt_val,
  input  logic               cnt_ovf,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [1:0]         pin_in,
  output logic [1:0]         pin_out,
  output logic [1:0]         pin_oe,
  output logic [1:0]         irq
);
  import tcp_pkg::*;

  logic [1:0]             rst_sync;
  logic                   rst_n_s;
  ctl_t [1:0]             ctl;
  logic [1:0][CNT_W-1:0]  cmp;
  logic [1:0][CNT_W-1:0]  cmp_eff;
  logic [1:0]             evt, cap_we, active;
  logic                   buf_en, use_odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  tcp_regs #(.CNT_W(CNT_W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt_val),
    .evt(evt), .cap_we(cap_we), .ctl(ctl), .cmp(cmp)
  );

  assign buf_en = ctl[0].mode_b;

  tcp_buf_sel u_sel (
    .clk(clk), .rst_n(rst_n_s), .buf_en(buf_en), .cnt_ovf(cnt_ovf),
    .use_odd(use_odd)
  );

  assign cmp_eff[0] = use_odd ? cmp[1] : cmp[0];
  assign cmp_eff[1] = cmp[1];
  assign active     = {!buf_en, 1'b1};

  for (genvar i = 0; i < 2; i++) begin : g_ch
    tcp_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n_s), .ctl(ctl[i]), .cmp_val(cmp_eff[i]),
      .cnt_val(cnt_val), .cnt_ovf(cnt_ovf), .pin_in(pin_in[i]),
      .active(active[i]), .evt(evt[i]), .cap_we(cap_we[i]),
      .pin_out(pin_out[i]), .pin_oe(pin_oe[i])
    );
    assign irq[i] = ctl[i].flag && ctl[i].ie;
  end

  p_odd_released_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    buf_en |-> (!pin_oe[1] && !evt[1]));
endmodule

// File: tb/tb_tmr_chan_pair.sv
`timescale 1ns/1ps
module tb_tmr_chan_pair;
  localparam logic [15:0] PARK = 16'hABCD;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt_val;
  logic        cnt_ovf;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [1:0]  pin_in, pin_out, pin_oe, irq;

  tmr_chan_pair dut (.*);

  always #2.5 clk = ~clk;

  typedef struct { string tag; int what; int idx; int exp; } item_t;
  item_t sbq[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic int observe(int what, int idx);
    case (what)
      0: return int'(bus_rdata);
      1: return int'(pin_out[idx]);
      2: return int'(pin_oe[idx]);
      default: return int'(irq[idx]);
    endcase
  endfunction

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      item_t it;
      int got;
      wait (sbq.size() > 0);
      it = sbq.pop_front();
      got = observe(it.what, it.idx);
      checks++;
      if (got != it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d idx=%0d actual=%h expected=%h",
                 it.tag, it.what, it.idx, got, it.exp);
      end
    end
  end

  task automatic push(string tag, int what, int idx, int exp);
    item_t it;
    it.tag = tag; it.what = what; it.idx = idx; it.exp = exp;
    sbq.push_back(it);
    wait (sbq.size() == 0);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; cnt_val = PARK; cnt_ovf = 1'b0;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [2:0] a, int exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    push(tag, 0, 0, exp);
  endtask

  task automatic tick(logic [15:0] v, logic ovf);
    @(negedge clk);
    cnt_val = v; cnt_ovf = ovf;
    @(negedge clk);
    cnt_val = PARK; cnt_ovf = 1'b0;
  endtask

  task automatic pin_tick(int ch, logic lvl, logic [15:0] v);
    @(negedge clk);
    cnt_val = v; pin_in[ch] = lvl;
    @(negedge clk);
    cnt_val = PARK;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt_val = PARK; cnt_ovf = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) rd_chk("R1 reg", 3'(a), 0);
    push("R1 oe0", 2, 0, 0); push("R1 oe1", 2, 1, 0);
    push("R1 out0", 1, 0, 0); push("R1 irq0", 3, 0, 0); push("R1 irq1", 3, 1, 0);

    // R3 layout, odd bit 5 reads 0
    wr(3, 8'hFF); rd_chk("R3 odd bit5", 3, 8'h5F); wr(3, 8'h00);
    wr(0, 8'h23); rd_chk("R3 even bit5", 0, 8'h23); wr(0, 8'h00);
    rd_chk("R3 unused addr", 7, 0);

    // R5 capture rising, R4 irq
    wr(0, 8'h44);
    pin_tick(0, 1'b1, 16'h1234);
    push("R4 irq set", 3, 0, 1);
    rd_chk("R5 cap hi", 1, 8'h12); rd_chk("R5 cap lo", 2, 8'h34);
    rd_chk("R2 flag set", 0, 8'hC4);
    wr(0, 8'h44); rd_chk("R2 clear by 0", 0, 8'h44); push("R4 irq clr", 3, 0, 0);
    wr(0, 8'hC4); rd_chk("R2 write 1 no effect", 0, 8'h44);
    pin_tick(0, 1'b0, 16'h2222);
    rd_chk("R5 fall ignored on rise sel", 2, 8'h34);
    wr(0, 8'h48);
    pin_tick(0, 1'b1, 16'h3333);
    pin_tick(0, 1'b0, 16'h4444);
    rd_chk("R5 fall cap hi", 1, 8'h44); rd_chk("R5 fall cap lo", 2, 8'h44);
    wr(3, 8'h0C);
    pin_tick(1, 1'b1, 16'h5555); rd_chk("R5 any rise", 4, 8'h55);
    pin_tick(1, 1'b0, 16'h6666); rd_chk("R5 any fall", 5, 8'h66);
    rd_chk("R5 odd flag", 3, 8'h8C);

    // R6 compare actions, R10 enable
    wr(0, 8'h1C); wr(1, 8'h01); wr(2, 8'h00);
    push("R10 oe on", 2, 0, 1); push("R6 out idle", 1, 0, 0);
    tick(16'h00FF, 1'b0); push("R6 no match", 1, 0, 0);
    tick(16'h0100, 1'b0); push("R6 set", 1, 0, 1);
    rd_chk("R6 flag", 0, 8'h9C); push("R4 ie off", 3, 0, 0);
    wr(0, 8'h18); tick(16'h0100, 1'b0); push("R6 clear", 1, 0, 0);
    wr(0, 8'h14); tick(16'h0100, 1'b0); push("R6 toggle a", 1, 0, 1);
    tick(16'h0100, 1'b0); push("R6 toggle b", 1, 0, 0);
    wr(0, 8'h10); push("R10 oe off", 2, 0, 0);
    tick(16'h0100, 1'b0); push("R10 hold", 1, 0, 0);

    // R7 overflow toggle and match priority
    wr(0, 8'h16);
    tick(16'h0000, 1'b1); push("R7 ovf toggle a", 1, 0, 1);
    tick(16'h0000, 1'b1); push("R7 ovf toggle b", 1, 0, 0);
    wr(0, 8'h1E);
    tick(16'h0000, 1'b1); push("R7 ovf toggle c", 1, 0, 1);
    tick(16'h0100, 1'b1); push("R7 match wins", 1, 0, 1);

    // R8 full duty
    wr(0, 8'h1A); tick(16'h0100, 1'b0); push("R8 prep low", 1, 0, 0);
    wr(0, 8'h1B); tick(16'h0000, 1'b0); push("R8 forced high", 1, 0, 1);
    tick(16'h0100, 1'b0); push("R8 match ignored", 1, 0, 1);
    rd_chk("R8 flag still set", 0, 8'h9B);

    // R9 buffered compare
    wr(4, 8'h02); wr(5, 8'h00); wr(3, 8'h1C);
    push("R10 odd oe", 2, 1, 1);
    wr(0, 8'h34);
    push("R9 odd released", 2, 1, 0); push("R9 even drives", 2, 0, 1);
    tick(16'h0200, 1'b0); push("R9 other reg idle", 1, 0, 1);
    tick(16'h0100, 1'b0); push("R9 first reg", 1, 0, 0);
    tick(16'h0000, 1'b1); push("R9 ovf no toggle", 1, 0, 0);
    tick(16'h0100, 1'b0); push("R9 first reg idle", 1, 0, 0);
    tick(16'h0200, 1'b0); push("R9 second reg", 1, 0, 1);
    rd_chk("R9 odd no flag", 3, 8'h1C);
    tick(16'h0000, 1'b1);
    tick(16'h0100, 1'b0); push("R9 back to first", 1, 0, 0);
    rd_chk("R9 even flag", 0, 8'hB4);

    // R2 event vs clearing write in one cycle
    wr(0, 8'h44); rd_chk("R2 cleared", 0, 8'h44);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h44;
    cnt_val = 16'h7777; pin_in[0] = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; cnt_val = PARK;
    rd_chk("R2 event beats clear", 0, 8'hC4);
    rd_chk("R5 collision capture", 1, 8'h77);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule